// File: doc/BRIEF.md
# Bus reset quiesce controller

This block lives inside a bus bridge, between the bridge's external-bus master and target paths and the chip's reset unit. A sideband input tells it that an internal bus reset is pending. In endpoint mode the block then shuts down the external bus activity in an orderly way. It withdraws or blocks new outbound requests and lets an in-flight outbound transfer finish on its own. It stops claiming new inbound cycles, which the initiators then see as master aborts, and it waits for any inbound cycle it has already claimed to end. Only then does it raise a ready-for-reset sideband output to the reset unit.

Once the reset unit answers with an apply strobe, the block drives one of two reset scopes. The partial scope clears queues and state machines and leaves configuration registers alone. The full scope clears everything, configuration included. A mode strap picks the scope. In central-resource mode there is no quiesce step: ready is reported at once, and the reset may be applied at any time. The strap is captured once after power-on reset. Inbound traffic toward the internal bus is not gated by this block.

Top module: `bus_rst_quiesce`

## Requirements
- R1: While rst_ni is low and right after it is released, req_en_o=1, claim_en_o=1, ready_o=0, part_rst_o=0 and full_rst_o=0.
- R2: Endpoint mode (mode_root_i=0 at capture): when rst_pend_i is high and no transaction has started (not both ob_busy_i=1 and xact_start_i=1), req_en_o drops in that same cycle. It stays low, including while a request was pending (ob_busy_i=1), until the reset has been applied and rst_pend_i is low.
- R3: Endpoint mode: if ob_busy_i=1 and xact_start_i=1 when rst_pend_i rises, req_en_o stays high until the first clock edge that samples ob_busy_i=0, and then stays low.
- R4: Endpoint mode: claim_en_o is low from the first cycle rst_pend_i is high until the reset period ends.
- R5: Endpoint mode: ready_o rises after clock edge max(1, A, B), counting the first edge with rst_pend_i high as edge 0. A is the edge that first samples ob_busy_i=0 for a started transfer, else 0. B is the edge that first samples ib_busy_i=0 if ib_busy_i was high, else 0.
- R6: ready_o stays high until the edge that samples rst_go_i=1, and clears at that edge.
- R7: In endpoint mode, the apply strobe asserts part_rst_o and never full_rst_o. The reset output lasts RST_CYC cycles, and longer while rst_pend_i stays high. Only one of part_rst_o and full_rst_o is ever high.
- R8: Central-resource mode (mode_root_i=1 at capture): req_en_o and claim_en_o stay high outside the reset period, whatever the bus activity. ready_o rises after the first edge with rst_pend_i high. The apply strobe asserts full_rst_o.
- R9: rst_go_i is accepted in central-resource mode at any time. In endpoint mode it is ignored unless ready_o is high.
- R10: The strap is captured at the first clock after rst_ni is released. Later changes of mode_root_i have no effect.
- R11: After the reset period ends, req_en_o and claim_en_o return high, and a new pending reset starts a new quiesce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mode_root_i | input | 1 | Mode strap: 1 central-resource, 0 endpoint |
| rst_pend_i | input | 1 | Internal bus reset pending, synchronous |
| rst_go_i | input | 1 | Reset unit applies the reset |
| ob_busy_i | input | 1 | Outbound master has a transaction queued or running |
| xact_start_i | input | 1 | The outbound transaction has started on the bus |
| ib_busy_i | input | 1 | A claimed inbound cycle is still running |
| req_en_o | output | 1 | Permission to assert the external bus request |
| claim_en_o | output | 1 | Permission to claim new inbound cycles |
| ready_o | output | 1 | Ready-for-reset sideband to the reset unit |
| part_rst_o | output | 1 | Reset of queues and state machines, configuration kept |
| full_rst_o | output | 1 | Reset of the whole bridge including configuration |

## Verification
The endpoint quiesce is swept over all eight combinations of outbound-busy, transaction-started and inbound-busy at the moment the reset becomes pending. Each combination is crossed with three release cycles for the outbound transfer and three for the inbound one. This separates a withdrawn request from an in-flight one, and shows which of the two drains sets the ready edge. Extra cases hold the pending input across the reset period to stretch it, pulse the apply strobe too early to show it is ignored, and flip the strap after capture in central-resource mode to show that the full scope and the open gates remain.

// File: rtl/bqc_pkg.sv
package bqc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_READY = 2'd2,
    ST_RESET = 2'd3
  } qsc_state_e;
endpackage

// File: rtl/bqc_strap.sv
module bqc_strap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic root_o,
  output logic vld_o
);
  // capture once, then frozen until the next power-on reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      root_o <= 1'b0;
      vld_o  <= 1'b0;
    end else if (!vld_o) begin
      root_o <= strap_i;
      vld_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/bqc_ob_track.sv
module bqc_ob_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic drain_i,
  input  logic ob_busy_i,
  input  logic xact_start_i,
  output logic inflight_o,
  output logic hold_o,
  output logic done_o
);
  logic hold_q;

  assign inflight_o = ob_busy_i & xact_start_i;

  // hold is only ever set on entry to drain; it can never be re-armed there
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= 1'b0;
    else if (arm_i)   hold_q <= inflight_o;
    else if (drain_i) hold_q <= hold_q & ob_busy_i;
    else              hold_q <= 1'b0;
  end

  assign hold_o = hold_q;
  assign done_o = ~hold_q | ~ob_busy_i;
endmodule

// File: rtl/bqc_rst_gen.sv
module bqc_rst_gen #(
  parameter int RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic active_i,
  input  logic root_i,
  output logic expired_o,
  output logic part_o,
  output logic full_o
);
  generate
    if (RST_CYC > 1) begin : g_cnt
      localparam int CW = (RST_CYC > 2) ? $clog2(RST_CYC) : 1;
      localparam logic [CW-1:0] LOAD = CW'(RST_CYC - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        cnt_q <= '0;
        else if (load_i)                    cnt_q <= LOAD;
        else if (active_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end

      assign expired_o = (cnt_q == '0);
    end else begin : g_min
      assign expired_o = 1'b1;
    end
  endgenerate

  assign part_o = active_i & ~root_i;
  assign full_o = active_i &  root_i;
endmodule

// File: rtl/bus_rst_quiesce.sv
module bus_rst_quiesce
  import bqc_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_root_i,
  input  logic rst_pend_i,
  input  logic rst_go_i,
  input  logic ob_busy_i,
  input  logic xact_start_i,
  input  logic ib_busy_i,
  output logic req_en_o,
  output logic claim_en_o,
  output logic ready_o,
  output logic part_rst_o,
  output logic full_rst_o
);
  qsc_state_e state_q, state_d;
  logic root_q, strap_vld;
  logic ep_gate;
  logic arm, load, expired;
  logic inflight, hold, ob_done;

  bqc_strap i_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (mode_root_i),
    .root_o  (root_q),
    .vld_o   (strap_vld)
  );

  bqc_ob_track i_ob (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (arm),
    .drain_i      (state_q == ST_DRAIN),
    .ob_busy_i    (ob_busy_i),
    .xact_start_i (xact_start_i),
    .inflight_o   (inflight),
    .hold_o       (hold),
    .done_o       (ob_done)
  );

  bqc_rst_gen #(.RST_CYC(RST_CYC)) i_rgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .active_i  (state_q == ST_RESET),
    .root_i    (root_q),
    .expired_o (expired),
    .part_o    (part_rst_o),
    .full_o    (full_rst_o)
  );

  // endpoint quiesce starts in the very cycle the pending flag shows up
  assign ep_gate = strap_vld & ~root_q & rst_pend_i;

  always_comb begin
    state_d = state_q;
    arm     = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (strap_vld) begin
          if (root_q) begin
            if (rst_go_i) begin
              state_d = ST_RESET;
              load    = 1'b1;
            end else if (rst_pend_i) begin
              state_d = ST_READY;
            end
          end else if (rst_pend_i) begin
            state_d = ST_DRAIN;
            arm     = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (ob_done && !ib_busy_i) state_d = ST_READY;
      end
      ST_READY: begin
        if (rst_go_i) begin
          state_d = ST_RESET;
          load    = 1'b1;
        end
      end
      ST_RESET: begin
        if (expired && !rst_pend_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE: begin
        req_en_o   = ep_gate ? inflight : 1'b1;
        claim_en_o = ~ep_gate;
      end
      ST_DRAIN: begin
        req_en_o   = hold;
        claim_en_o = 1'b0;
      end
      ST_READY: begin
        req_en_o   = root_q;
        claim_en_o = root_q;
      end
      default: begin
        req_en_o   = 1'b0;
        claim_en_o = 1'b0;
      end
    endcase
  end

  assign ready_o = (state_q == ST_READY);
endmodule

// File: rtl/bqc_chk.sv
module bqc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic root_q,
  input logic rst_pend_i,
  input logic rst_go_i,
  input logic ib_busy_i,
  input logic req_en_o,
  input logic claim_en_o,
  input logic ready_o,
  input logic part_rst_o,
  input logic full_rst_o
);
  // R2
  no_rereq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!root_q && rst_pend_i && !req_en_o) |=> !req_en_o);

  // R4
  no_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!root_q && (ready_o || part_rst_o)) |-> !claim_en_o);

  // R5
  ready_ib_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && !root_q) |-> $past(!ib_busy_i));

  // R6
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !rst_go_i) |=> ready_o);

  // R7
  scope_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(part_rst_o && full_rst_o));

  // R7
  part_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(part_rst_o) |-> $past(ready_o));

  // R8
  root_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (root_q && !full_rst_o) |-> (req_en_o && claim_en_o));
endmodule

bind bus_rst_quiesce bqc_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .root_q     (root_q),
  .rst_pend_i (rst_pend_i),
  .rst_go_i   (rst_go_i),
  .ib_busy_i  (ib_busy_i),
  .req_en_o   (req_en_o),
  .claim_en_o (claim_en_o),
  .ready_o    (ready_o),
  .part_rst_o (part_rst_o),
  .full_rst_o (full_rst_o)
);

// File: tb/test_bus_rst_quiesce.sv
`timescale 1ns/1ps
module test_bus_rst_quiesce;
  logic clk = 1'b0, rst_n = 1'b0;
  logic root = 1'b0, pend = 1'b0, go = 1'b0, obb = 1'b0, st = 1'b0, ibb = 1'b0;
  logic req_en, claim_en, ready, part_rst, full_rst;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_rst_quiesce #(.RST_CYC(4)) i_bus_rst_quiesce (
    .clk_i(clk), .rst_ni(rst_n), .mode_root_i(root), .rst_pend_i(pend),
    .rst_go_i(go), .ob_busy_i(obb), .xact_start_i(st), .ib_busy_i(ibb),
    .req_en_o(req_en), .claim_en_o(claim_en), .ready_o(ready),
    .part_rst_o(part_rst), .full_rst_o(full_rst)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic por(bit r);
    rst_n = 1'b0; root = r; pend = 0; go = 0; obb = 0; st = 0; ibb = 0;
    repeat (2) cyc();
    // R1 reset state during reset
    chk("R1 req_en in reset", req_en, 1);
    chk("R1 claim_en in reset", claim_en, 1);
    chk("R1 ready in reset", ready, 0);
    chk("R1 resets in reset", {part_rst, full_rst}, 0);
    rst_n = 1'b1;
    repeat (2) cyc();
  endtask

  initial begin
    por(1'b0);
    chk("R1 req_en after reset", req_en, 1);
    chk("R1 claim_en after reset", claim_en, 1);
    chk("R1 ready after reset", ready, 0);

    // R9 endpoint: apply strobe ignored while idle
    go = 1; cyc(); go = 0;
    chk("R9 part_rst on idle go", part_rst, 0);
    chk("R9 req_en on idle go", req_en, 1);
    cyc();
    chk("R9 part_rst later", part_rst, 0);

    // endpoint sweep
    for (int c = 0; c < 8; c++) begin
      for (int a = 1; a <= 3; a++) begin
        for (int b = 1; b <= 3; b++) begin
          automatic bit ob = c[2], s = c[1], ib = c[0];
          automatic bit hold = ob & s;
          automatic int ae = hold ? a : 0;
          automatic int be = ib ? b : 0;
          automatic int rdy = 1;
          if (ae > rdy) rdy = ae;
          if (be > rdy) rdy = be;
          pend = 1; obb = ob; st = s; ibb = ib;
          #1;
          if (hold) chk("R3 req_en kept for started transfer", req_en, 1);
          else      chk("R2 req_en withdrawn", req_en, 0);
          chk("R4 claim_en off", claim_en, 0);
          for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            if (n + 1 == a) obb = 0;
            if (n + 1 == b) ibb = 0;
            #1;
            chk("R5 ready edge", ready, (n >= rdy) ? 1 : 0);
            chk("R3 req_en drain", req_en, (hold && n < a) ? 1 : 0);
            chk("R4 claim_en drain", claim_en, 0);
          end
          go = 1; cyc(); go = 0; pend = 0; obb = 0; st = 0; ibb = 0;
          chk("R6 ready cleared by go", ready, 0);
          for (int i = 0; i < 4; i++) begin
            chk("R7 part_rst asserted", part_rst, 1);
            chk("R7 full_rst off", full_rst, 0);
            chk("R2 req_en off in reset", req_en, 0);
            cyc();
          end
          chk("R7 part_rst ended", part_rst, 0);
          chk("R11 req_en back", req_en, 1);
          chk("R11 claim_en back", claim_en, 1);
        end
      end
    end

    // R9 endpoint: go during drain ignored; R7 stretched by pending
    pend = 1; ibb = 1; cyc(); cyc();
    chk("R5 ready waits for inbound", ready, 0);
    go = 1; cyc(); go = 0;
    chk("R9 go ignored in drain ready", ready, 0);
    chk("R9 go ignored in drain part", part_rst, 0);
    ibb = 0; cyc();
    chk("R5 ready after inbound ends", ready, 1);
    cyc();
    chk("R6 ready held", ready, 1);
    go = 1; cyc(); go = 0;
    for (int i = 0; i < 6; i++) begin
      chk("R7 part_rst stretched", part_rst, 1);
      if (i == 5) pend = 0;
      cyc();
    end
    chk("R7 stretched reset ended", part_rst, 0);
    chk("R11 req_en after stretch", req_en, 1);

    // central-resource mode
    por(1'b1);
    root = 0;
    pend = 1; ibb = 1; obb = 1; st = 1; #1;
    chk("R8 req_en open", req_en, 1);
    chk("R8 claim_en open", claim_en, 1);
    cyc();
    chk("R8 ready without quiesce", ready, 1);
    chk("R8 claim_en still open", claim_en, 1);
    go = 1; cyc(); go = 0; pend = 0; ibb = 0; obb = 0; st = 0;
    chk("R10 full_rst after strap change", full_rst, 1);
    chk("R8 part_rst off", part_rst, 0);
    chk("R6 ready cleared", ready, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R8 full_rst length", full_rst, 1);
      cyc();
    end
    chk("R8 full_rst ended", full_rst, 0);
    go = 1; cyc(); go = 0;
    chk("R9 root go at any time", full_rst, 1);
    repeat (5) cyc();
    chk("R11 root idle again", {req_en, claim_en, full_rst}, 3'b110);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule